// File: doc/BRIEF.md
# Half-Bridge PWM Generator with Break-Before-Make and Soft-Start

This block produces the gate commands for the two primary switches of a half-bridge converter and the two synchronous-rectifier commands for its secondary side. A fixed-length switching period is divided into two equal halves. The high-side switch may conduct only in the first half of the period and the low-side switch only in the second half. The length of a half period, the on-time command, its lower and upper limits, the soft-start step and the dead time are all digital words given in clock cycles.

Inside each half period, primary turn-on is delayed by the dead time. The opposite rectifier is released a full dead time after the primary switch has turned off. Primary and secondary conduction therefore never overlap. The rectifier commands are active low, because the isolation path inverts them. When the block is enabled, the on-time starts at the lower limit and rises by a fixed step once per full period until it reaches the upper limit. A shutdown request turns every output off in the same cycle and restarts the sequence when it is released.

Top module: `hb_pwm_gen`

## Requirements
- R1: While `enable` is low, and in reset, `hs_on` and `ls_on` are 0 and `sync_a_n` and `sync_b_n` are 1. Taking `enable` low takes effect at the next clock edge.
- R2: After `enable` is sampled high, the block runs in half periods of `half_len` cycles each (`half_len` at least 2). The first half and every even half are high-side halves. The odd halves are low-side halves. `hs_on` and `ls_on` are never 1 together.
- R3: In a half period with on-time D and dead time T, the primary output of that half is 1 at counts T through D-1 of the half, counting from 0, and is 0 at every other count.
- R4: In a high-side half, `sync_a_n` is 0 for the whole half. `sync_b_n` is 1 at counts 0 through D+T-1 and 0 after that. A low-side half is the mirror image, with `sync_a_n` and `sync_b_n` exchanged. A value of 0 means the rectifier is on.
- R5: Whenever a primary output is 1, the rectifier of the opposite leg is off. The two rectifier commands are never both 0 in that cycle.
- R6: The on-time command `duty_cmd` is clamped to the range from `duty_min` to `duty_max` before it is used.
- R7: Counting full periods from 0 after enable, period k uses a ramp value of `duty_min` + k·`ss_step`, saturated at `duty_max`. The on-time of each half is the smaller of the clamped command and the ramp value.
- R8: The command and the dead time are sampled only on the last cycle of a half period. A change in the middle of a half affects only later halves.
- R9: While `shutdown` is 1, in the same cycle, both primary outputs are 0 and both rectifier commands are 1. After release, the block restarts with a high-side half at the start of the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; rising starts the soft-start sequence |
| shutdown | input | 1 | Immediate stop of all outputs |
| half_len | input | CNT_W | Cycles per half period |
| duty_cmd | input | CNT_W | On-time command in cycles |
| duty_min | input | CNT_W | Lower on-time limit and ramp start |
| duty_max | input | CNT_W | Upper on-time limit and ramp end |
| ss_step | input | CNT_W | Ramp increment per full period |
| dead_len | input | CNT_W | Dead time in cycles |
| hs_on | output | 1 | High-side primary gate command |
| ls_on | output | 1 | Low-side primary gate command |
| sync_a_n | output | 1 | Rectifier A command, active low |
| sync_b_n | output | 1 | Rectifier B command, active low |

## Verification
The first edge that samples `enable` or the release of `shutdown` high puts the block at count 0 of a high-side half. The bench starts its sample index at the falling edge that follows that rising edge, and compares all four outputs against a waveform computed from R3, R4 and R7 at every index. A change of command made just after sample i is due in the first half whose last cycle comes at index i or later. The bench predicts that half from the half length. A raised `shutdown` is checked 1 ns later in the same cycle. A lowered `enable` is checked at the next falling edge.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;
  // Which primary leg owns the current half period
  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;

  localparam int LEGS = 2;
endpackage

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase
  import hbpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half_len,
  output logic             act,
  output logic [CNT_W-1:0] cnt,
  output phase_e           phase,
  output logic             half_end,
  output logic             period_end
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign half_end   = act && (cnt >= half_len - ONE);
  assign period_end = half_end && (phase == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      cnt   <= '0;
      phase <= PH_HIGH;
    end else if (!run) begin
      act   <= 1'b0;
      cnt   <= '0;
      phase <= PH_HIGH;
    end else begin
      act <= 1'b1;
      if (act) begin
        if (half_end) begin
          cnt   <= '0;
          phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/hbpwm_duty.sv
module hbpwm_duty #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             half_end,
  input  logic             period_end,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] duty_min,
  input  logic [CNT_W-1:0] duty_max,
  input  logic [CNT_W-1:0] ss_step,
  input  logic [CNT_W-1:0] dead_in,
  output logic [CNT_W-1:0] on_q,
  output logic [CNT_W-1:0] dead_q
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] ramp_q, ramp_nxt, clamped, on_nxt, ramp_sat;
  logic [SUM_W-1:0] ramp_sum;

  always_comb begin
    if (duty_cmd < duty_min)      clamped = duty_min;
    else if (duty_cmd > duty_max) clamped = duty_max;
    else                          clamped = duty_cmd;
  end

  assign ramp_sum = {1'b0, ramp_q} + {1'b0, ss_step};
  assign ramp_sat = (ramp_sum >= {1'b0, duty_max}) ? duty_max : ramp_sum[CNT_W-1:0];
  assign ramp_nxt = period_end ? ramp_sat : ramp_q;
  assign on_nxt   = (clamped < ramp_nxt) ? clamped : ramp_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      on_q   <= '0;
      dead_q <= '0;
    end else if (!run) begin
      ramp_q <= duty_min;
      on_q   <= duty_min;
      dead_q <= dead_in;
    end else if (half_end) begin
      ramp_q <= ramp_nxt;
      on_q   <= on_nxt;
      dead_q <= dead_in;
    end
  end
endmodule

// File: rtl/hbpwm_outgen.sv
module hbpwm_outgen
  import hbpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             act,
  input  logic             shutdown,
  input  phase_e           phase,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] on_q,
  input  logic [CNT_W-1:0] dead_q,
  output logic [LEGS-1:0]  pri_on,
  output logic [LEGS-1:0]  sec_n
);
  localparam int SUM_W = CNT_W + 1;

  logic             gate, pri_win, sec_off;
  logic [SUM_W-1:0] sec_end;

  assign gate    = act && !shutdown;
  assign sec_end = {1'b0, on_q} + {1'b0, dead_q};
  assign pri_win = gate && (cnt >= dead_q) && (cnt < on_q);
  assign sec_off = gate && ({1'b0, cnt} < sec_end);

  // leg 0: high-side switch / rectifier A, leg 1: low-side switch / rectifier B
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    localparam phase_e OWN_PH   = (g == 0) ? PH_HIGH : PH_LOW;
    localparam phase_e OTHER_PH = (g == 0) ? PH_LOW  : PH_HIGH;
    assign pri_on[g] = pri_win && (phase == OWN_PH);
    assign sec_n[g]  = !gate || ((phase == OTHER_PH) && sec_off);
  end
endmodule

// File: rtl/hb_pwm_gen.sv
module hb_pwm_gen
  import hbpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             shutdown,
  input  logic [CNT_W-1:0] half_len,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] duty_min,
  input  logic [CNT_W-1:0] duty_max,
  input  logic [CNT_W-1:0] ss_step,
  input  logic [CNT_W-1:0] dead_len,
  output logic             hs_on,
  output logic             ls_on,
  output logic             sync_a_n,
  output logic             sync_b_n
);
  logic             run, act, half_end, period_end;
  logic [CNT_W-1:0] cnt, on_q, dead_q;
  phase_e           phase;
  logic [LEGS-1:0]  pri_on, sec_n;

  assign run = enable && !shutdown;

  hbpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .half_len(half_len),
    .act(act), .cnt(cnt), .phase(phase),
    .half_end(half_end), .period_end(period_end)
  );

  hbpwm_duty #(.CNT_W(CNT_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .run(run),
    .half_end(half_end), .period_end(period_end),
    .duty_cmd(duty_cmd), .duty_min(duty_min), .duty_max(duty_max),
    .ss_step(ss_step), .dead_in(dead_len),
    .on_q(on_q), .dead_q(dead_q)
  );

  hbpwm_outgen #(.CNT_W(CNT_W)) u_out (
    .act(act), .shutdown(shutdown), .phase(phase), .cnt(cnt),
    .on_q(on_q), .dead_q(dead_q), .pri_on(pri_on), .sec_n(sec_n)
  );

  assign hs_on    = pri_on[0];
  assign ls_on    = pri_on[1];
  assign sync_a_n = sec_n[0];
  assign sync_b_n = sec_n[1];
endmodule

// File: rtl/hb_pwm_gen_chk.sv
module hb_pwm_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic shutdown,
  input logic hs_on,
  input logic ls_on,
  input logic sync_a_n,
  input logic sync_b_n
);
  // R2
  legs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  // R5
  hs_rect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on |-> (sync_b_n && !sync_a_n));

  // R5
  ls_rect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on |-> (sync_a_n && !sync_b_n));

  // R9
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!hs_on && !ls_on && sync_a_n && sync_b_n));

  // R1
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_on && !ls_on && sync_a_n && sync_b_n));
endmodule

bind hb_pwm_gen hb_pwm_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .shutdown(shutdown),
  .hs_on(hs_on), .ls_on(ls_on), .sync_a_n(sync_a_n), .sync_b_n(sync_b_n)
);

// File: tb/hb_pwm_gen_tb.sv
`timescale 1ns/1ps
module hb_pwm_gen_tb;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic             shutdown = 1'b0;
  logic [CNT_W-1:0] half_len = 16'd20;
  logic [CNT_W-1:0] duty_cmd = '0;
  logic [CNT_W-1:0] duty_min = '0;
  logic [CNT_W-1:0] duty_max = '0;
  logic [CNT_W-1:0] ss_step = '0;
  logic [CNT_W-1:0] dead_len = '0;
  logic hs_on, ls_on, sync_a_n, sync_b_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model settings
  int mH, mT, mMin, mMax, mStep, cmdOld, cmdNew, chgIdx;

  always #2.5 clk = ~clk;

  hb_pwm_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .shutdown(shutdown),
    .half_len(half_len), .duty_cmd(duty_cmd), .duty_min(duty_min),
    .duty_max(duty_max), .ss_step(ss_step), .dead_len(dead_len),
    .hs_on(hs_on), .ls_on(ls_on), .sync_a_n(sync_a_n), .sync_b_n(sync_b_n)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int on_of_half(int h);
    int k, r, c;
    k = h / 2;
    r = mMin + k * mStep;
    if (r > mMax) r = mMax;
    c = (chgIdx >= 0 && (h * mH - 1) >= chgIdx) ? cmdNew : cmdOld;
    if (c < mMin) c = mMin;
    if (c > mMax) c = mMax;
    return (c < r) ? c : r;
  endfunction

  task automatic setup(int h, int t, int mn, int mx, int st, int cmd);
    mH = h; mT = t; mMin = mn; mMax = mx; mStep = st; cmdOld = cmd;
    cmdNew = cmd; chgIdx = -1;
    half_len = CNT_W'(h); dead_len = CNT_W'(t); duty_min = CNT_W'(mn);
    duty_max = CNT_W'(mx); ss_step = CNT_W'(st); duty_cmd = CNT_W'(cmd);
  endtask

  // Called right after the edge that made the block active (index 0 = count 0)
  task automatic run_model(int nh, string req);
    int bad_hs = 0, bad_ls = 0, bad_a = 0, bad_b = 0, ovl = 0, bbm = 0;
    int first_idx = -1;
    for (int i = 0; i < nh * mH; i++) begin
      int h, c, d;
      bit pri, eh, el, ea, eb, off;
      @(negedge clk);
      h = i / mH; c = i % mH; d = on_of_half(h);
      pri = (c >= mT) && (c < d);
      off = (c < d + mT);
      eh = pri && (h % 2 == 0);
      el = pri && (h % 2 == 1);
      ea = (h % 2 == 1) ? off : 1'b0;
      eb = (h % 2 == 0) ? off : 1'b0;
      if (hs_on !== eh) bad_hs++;
      if (ls_on !== el) bad_ls++;
      if (sync_a_n !== ea) bad_a++;
      if (sync_b_n !== eb) bad_b++;
      if ((hs_on !== eh || ls_on !== el || sync_a_n !== ea || sync_b_n !== eb) && first_idx < 0)
        first_idx = i;
      if (hs_on && ls_on) ovl++;
      if ((hs_on || ls_on) && !sync_a_n && !sync_b_n) bbm++;
      if (i == chgIdx) duty_cmd = CNT_W'(cmdNew);
    end
    check(bad_hs == 0, {req, " R3"}, "hs_on mismatch cycles", bad_hs, 0);
    check(bad_ls == 0, {req, " R3"}, "ls_on mismatch cycles", bad_ls, 0);
    check(bad_a == 0, {req, " R4"}, "sync_a_n mismatch cycles", bad_a, 0);
    check(bad_b == 0, {req, " R4"}, "sync_b_n mismatch cycles", bad_b, 0);
    check(ovl == 0, "R2", "primary overlap cycles", ovl, 0);
    check(bbm == 0, "R5", "rectifiers both on during primary", bbm, 0);
    if (first_idx >= 0) $display("  first mismatch at sample %0d (%s)", first_idx, req);
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable = 1'b0; shutdown = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic start();
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!hs_on && !ls_on, "R1", "primaries in reset", {hs_on, ls_on}, 0);
    check(sync_a_n && sync_b_n, "R1", "rectifiers in reset", {sync_a_n, sync_b_n}, 3);
  endtask

  task automatic t_steady();  // R2 R3 R4 R5
    go_idle(); setup(20, 2, 4, 14, 20, 10); start();
    run_model(8, "R2 steady");
  endtask

  task automatic t_ramp();  // R7
    go_idle(); setup(24, 1, 2, 16, 3, 16); start();
    run_model(14, "R7 ramp");
  endtask

  task automatic t_clamp();  // R6
    go_idle(); setup(16, 2, 6, 12, 16, 1); start();
    run_model(6, "R6 clamp-low");
    go_idle(); setup(16, 2, 6, 12, 16, 40); start();
    run_model(6, "R6 clamp-high");
  endtask

  task automatic t_dead0();  // R3 R4 with zero dead time
    go_idle(); setup(12, 0, 3, 9, 9, 7); start();
    run_model(6, "R3 dead-zero");
  endtask

  task automatic t_midchange();  // R8
    go_idle(); setup(20, 3, 4, 15, 20, 6);
    chgIdx = 47; cmdNew = 12;
    start();
    run_model(10, "R8 mid-half");
  endtask

  task automatic t_shutdown();  // R9
    go_idle(); setup(20, 2, 4, 14, 20, 10); start();
    repeat (46) @(negedge clk);  // sample index 45: high side on
    check(hs_on == 1'b1, "R9", "hs_on before shutdown", hs_on, 1);
    shutdown = 1'b1;
    #1;
    check(!hs_on && !ls_on, "R9", "primaries same cycle", {hs_on, ls_on}, 0);
    check(sync_a_n && sync_b_n, "R9", "rectifiers same cycle", {sync_a_n, sync_b_n}, 3);
    repeat (3) @(negedge clk);
    check(!hs_on && !ls_on && sync_a_n && sync_b_n, "R9", "held quiet",
          {hs_on, ls_on, sync_a_n, sync_b_n}, 3);
    shutdown = 1'b0;
    @(posedge clk);
    run_model(6, "R9 restart");
  endtask

  task automatic t_disable();  // R1
    go_idle(); setup(20, 2, 4, 14, 20, 10); start();
    repeat (46) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!hs_on && !ls_on, "R1", "primaries after disable", {hs_on, ls_on}, 0);
    check(sync_a_n && sync_b_n, "R1", "rectifiers after disable", {sync_a_n, sync_b_n}, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_steady();
    t_ramp();
    t_clamp();
    t_dead0();
    t_midchange();
    t_shutdown();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule